// File: doc/BRIEF.md
# Auto-Reload Programmable Interval Timer

This block counts down from a value that software writes into a reload register. The counter moves one step on each cycle where the timebase tick input is high. When the count runs out, the block sets a sticky expiry flag. Software clears that flag by pulsing a clear input. An interrupt output is high while the flag is set and the timer is enabled.

After an expiry, the timer reloads and starts another period only if auto-reload is on. Otherwise it stops, and the count reads zero.

A reload value of 0 or 1 never starts the timer. A write to the reload register restarts counting from the new value, as long as the timer is enabled. A write to the control bits is handled as though an expiry had just happened. If the timer is enabled, auto-reload is on and the stored reload value is greater than 1, the count restarts from the stored reload value. Otherwise the timer stops.

A reload value of N gives an expiry on the N-th tick after the load.

Top module: `pit_timer`

## Requirements
- R1: When `reloadWrEn` is high, the value on `reloadWrData` is stored. If the effective enable is 1 and that value is greater than 1, `count` equals that value on the next cycle.
- R2: A reload value of 0 or 1 leaves the timer stopped. `count` stays 0 and no tick can set `status`.
- R3: While the enable bit is 0, the timer does not run. `count` is 0 and ticks have no effect on it.
- R4: A tick at count 1 sets `status` on the next cycle. `status` then stays 1 until a cycle with `statusClr` high and no expiry. If an expiry and a clear fall in the same cycle, the expiry wins.
- R5: `irq` equals `status` AND the enable bit. Clearing the enable bit masks the interrupt but leaves `status` unchanged.
- R6: At expiry with auto-reload 1, `count` restarts from the stored reload value. At expiry with auto-reload 0, the timer stops and `count` becomes 0.
- R7: A control write (`ctrlWrEn` high) takes the new enable and auto-reload bits. If both are 1 and the stored reload value is greater than 1, `count` restarts from the stored reload value. Otherwise the timer stops with `count` 0.
- R8: While running, `count` drops by exactly 1 on each tick. On a cycle with no tick and no write, `count` holds its value.
- R9: `count` reads 0 whenever the timer is stopped, including straight after reset. After reset, `status` and `irq` are also 0.
- R10: A reload write takes priority over a control write, and a control write takes priority over a tick in the same cycle. A tick that coincides with a write is dropped, and no expiry happens for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reloadWrEn | input | 1 | Write strobe for the reload register |
| reloadWrData | input | CNT_W | Reload value to store |
| ctrlWrEn | input | 1 | Write strobe for the control bits |
| ctrlEnable | input | 1 | New enable bit, taken when `ctrlWrEn` is high |
| ctrlAutoReload | input | 1 | New auto-reload bit, taken when `ctrlWrEn` is high |
| tick | input | 1 | Timebase tick; one count step per high cycle |
| statusClr | input | 1 | Write-one-to-clear pulse for the expiry flag |
| count | output | CNT_W | Current down-counter value; 0 when stopped |
| status | output | 1 | Sticky expiry flag |
| irq | output | 1 | Interrupt request: expiry flag gated by enable |

## Verification
The assertions check the following on every cycle:
- a stopped timer reads zero;
- a running timer never holds a zero count or a reload value below 2;
- a tick lowers the count by exactly one, and with no tick and no write the count holds;
- the expiry flag never drops without a clear;
- an expiry without auto-reload stops the timer.

Only the bench's scenarios can show the following, because each needs a planned sequence of writes and ticks:
- that the period equals the reload value;
- that auto-reload produces a second period;
- that a control write restarts or stops the timer;
- that enable masks the interrupt without touching the flag;
- that a write drops a same-cycle tick.

// File: rtl/pit_pkg.sv
package pit_pkg;

  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic loadWr;   // load count from write data
    logic loadReg;  // load count from stored reload value
    logic clear;    // force count to zero
    logic dec;      // decrement count
    logic setSts;   // set sticky expiry flag
  } pitStrobe_t;

  // Conditions reported by the datapath
  typedef struct packed {
    logic wrLoadable;   // write data > 1
    logic regLoadable;  // stored reload > 1
    logic atOne;        // count == 1
  } pitFlags_t;

endpackage

// File: rtl/pit_datapath.sv
module pit_datapath
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reloadWrEn,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic             statusClr,
  input  pitStrobe_t       strobe,
  output pitFlags_t        flags,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] reloadValue,
  output logic             status
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] reloadQ;
  logic             statusQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadQ <= '0;
    end else if (reloadWrEn) begin
      reloadQ <= reloadWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ <= '0;
    end else if (strobe.loadWr) begin
      countQ <= reloadWrData;
    end else if (strobe.loadReg) begin
      countQ <= reloadQ;
    end else if (strobe.clear) begin
      countQ <= '0;
    end else if (strobe.dec) begin
      countQ <= countQ - ONE;
    end
  end

  // Set has priority over clear
  always_ff @(posedge clk) begin
    if (!rstN) begin
      statusQ <= 1'b0;
    end else if (strobe.setSts) begin
      statusQ <= 1'b1;
    end else if (statusClr) begin
      statusQ <= 1'b0;
    end
  end

  always_comb begin
    flags.wrLoadable  = reloadWrData > ONE;
    flags.regLoadable = reloadQ > ONE;
    flags.atOne       = countQ == ONE;
  end

  assign count       = countQ;
  assign reloadValue = reloadQ;
  assign status      = statusQ;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    statusQ && !statusClr |=> statusQ); // R4

  AST_STATUS_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setSts |=> statusQ); // R4

endmodule

// File: rtl/pit_control.sv
module pit_control
  import pit_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reloadWrEn,
  input  logic       ctrlWrEn,
  input  logic       ctrlEnable,
  input  logic       ctrlAutoReload,
  input  logic       tick,
  input  pitFlags_t  flags,
  output pitStrobe_t strobe,
  output logic       running,
  output logic       enable
);

  logic enableQ, autoQ, runQ;
  logic enNext, autoNext, runNext;

  assign enNext   = ctrlWrEn ? ctrlEnable     : enableQ;
  assign autoNext = ctrlWrEn ? ctrlAutoReload : autoQ;

  // Priority: reload write, then control write, then tick
  always_comb begin
    strobe  = '0;
    runNext = runQ;
    if (reloadWrEn) begin
      if (enNext && flags.wrLoadable) begin
        strobe.loadWr = 1'b1;
        runNext       = 1'b1;
      end else begin
        strobe.clear = 1'b1;
        runNext      = 1'b0;
      end
    end else if (ctrlWrEn) begin
      if (enNext && autoNext && flags.regLoadable) begin
        strobe.loadReg = 1'b1;
        runNext        = 1'b1;
      end else begin
        strobe.clear = 1'b1;
        runNext      = 1'b0;
      end
    end else if (runQ && tick) begin
      if (flags.atOne) begin
        strobe.setSts = 1'b1;
        if (autoQ && flags.regLoadable) begin
          strobe.loadReg = 1'b1;
        end else begin
          strobe.clear = 1'b1;
          runNext      = 1'b0;
        end
      end else begin
        strobe.dec = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= 1'b0;
      autoQ   <= 1'b0;
      runQ    <= 1'b0;
    end else begin
      enableQ <= enNext;
      autoQ   <= autoNext;
      runQ    <= runNext;
    end
  end

  assign running = runQ;
  assign enable  = enableQ;

  AST_STOP_WITHOUT_AUTO: assert property (@(posedge clk) disable iff (!rstN)
    runQ && tick && flags.atOne && !autoQ && !reloadWrEn && !ctrlWrEn
    |=> !runQ); // R6

  AST_SMALL_RELOAD_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    reloadWrEn && !flags.wrLoadable |=> !runQ); // R2

  AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !enableQ |-> !runQ); // R3

endmodule

// File: rtl/pit_timer.sv
module pit_timer
  import pit_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reloadWrEn,
  input  logic [CNT_W-1:0] reloadWrData,
  input  logic             ctrlWrEn,
  input  logic             ctrlEnable,
  input  logic             ctrlAutoReload,
  input  logic             tick,
  input  logic             statusClr,
  output logic [CNT_W-1:0] count,
  output logic             status,
  output logic             irq
);

  pitStrobe_t       strobe;
  pitFlags_t        flags;
  logic             running;
  logic             enable;
  logic [CNT_W-1:0] reloadValue;

  pit_control u_control (
    .clk            (clk),
    .rstN           (rstN),
    .reloadWrEn     (reloadWrEn),
    .ctrlWrEn       (ctrlWrEn),
    .ctrlEnable     (ctrlEnable),
    .ctrlAutoReload (ctrlAutoReload),
    .tick           (tick),
    .flags          (flags),
    .strobe         (strobe),
    .running        (running),
    .enable         (enable)
  );

  pit_datapath #(.CNT_W(CNT_W)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .reloadWrEn   (reloadWrEn),
    .reloadWrData (reloadWrData),
    .statusClr    (statusClr),
    .strobe       (strobe),
    .flags        (flags),
    .count        (count),
    .reloadValue  (reloadValue),
    .status       (status)
  );

  assign irq = status & enable;

  AST_IDLE_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    !running |-> count == '0); // R9

  AST_RUN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (count != '0) && (reloadValue > CNT_W'(1))); // R2

  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rstN)
    running && tick && !reloadWrEn && !ctrlWrEn && count > CNT_W'(1)
    |=> count == $past(count) - CNT_W'(1)); // R8

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rstN)
    !tick && !reloadWrEn && !ctrlWrEn |=> $stable(count)); // R8

endmodule

// File: tb/pit_timer_test.sv
module pit_timer_test;

  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rstN;
  logic             reloadWrEn;
  logic [CNT_W-1:0] reloadWrData;
  logic             ctrlWrEn;
  logic             ctrlEnable;
  logic             ctrlAutoReload;
  logic             tick;
  logic             statusClr;
  logic [CNT_W-1:0] count;
  logic             status;
  logic             irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;  // 125 MHz

  pit_timer #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rstN(rstN), .reloadWrEn(reloadWrEn), .reloadWrData(reloadWrData),
    .ctrlWrEn(ctrlWrEn), .ctrlEnable(ctrlEnable), .ctrlAutoReload(ctrlAutoReload),
    .tick(tick), .statusClr(statusClr), .count(count), .status(status), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Every task starts and ends at a negedge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic doReload(input int v);
    reloadWrEn = 1'b1; reloadWrData = CNT_W'(v);
    step();
    reloadWrEn = 1'b0;
  endtask

  task automatic doCtrl(input bit en, input bit ar);
    ctrlWrEn = 1'b1; ctrlEnable = en; ctrlAutoReload = ar;
    step();
    ctrlWrEn = 1'b0;
  endtask

  task automatic doTicks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      step();
      tick = 1'b0;
    end
  endtask

  task automatic doClr();
    statusClr = 1'b1;
    step();
    statusClr = 1'b0;
  endtask

  task automatic testReset();
    check("R9 reset count", count, 0);
    check("R9 reset status", status, 0);
    check("R9 reset irq", irq, 0);
  endtask

  task automatic testDisabled();
    doCtrl(1'b0, 1'b0);
    doReload(5);
    check("R3 disabled reload count", count, 0);
    doTicks(3);
    check("R3 disabled ticks count", count, 0);
    check("R3 disabled status", status, 0);
  endtask

  task automatic testAutoRun();
    doCtrl(1'b1, 1'b1);
    check("R7 ctrl restart count", count, 5);
    repeat (4) step();
    check("R8 no tick hold", count, 5);
    doTicks(1);
    check("R8 one tick", count, 4);
    doTicks(3);
    check("R8 at one", count, 1);
    check("R4 no early expiry", status, 0);
    doTicks(1);
    check("R4 expiry status", status, 1);
    check("R5 irq raised", irq, 1);
    check("R6 auto reload count", count, 5);
    doTicks(5);
    check("R6 second period count", count, 5);
    check("R4 still set", status, 1);
  endtask

  task automatic testMask();
    doCtrl(1'b0, 1'b1);
    check("R5 masked irq", irq, 0);
    check("R5 status kept", status, 1);
    check("R7 disable stops", count, 0);
    doCtrl(1'b1, 1'b1);
    check("R5 irq unmasked", irq, 1);
    check("R7 reenable restart", count, 5);
  endtask

  task automatic testClear();
    doClr();
    check("R4 cleared status", status, 0);
    check("R4 cleared irq", irq, 0);
    repeat (3) step();
    check("R4 stays clear", status, 0);
    // expiry and clear in the same cycle: expiry wins
    doTicks(4);
    tick = 1'b1; statusClr = 1'b1;
    step();
    tick = 1'b0; statusClr = 1'b0;
    check("R4 set beats clear", status, 1);
    doClr();
  endtask

  task automatic testOneShot();
    doCtrl(1'b1, 1'b0);
    check("R7 ctrl without auto stops", count, 0);
    doReload(3);
    check("R1 reload loads", count, 3);
    doTicks(3);
    check("R6 one shot status", status, 1);
    check("R6 one shot stopped", count, 0);
    doTicks(2);
    check("R9 stopped stays zero", count, 0);
    doClr();
  endtask

  task automatic testSmallReload();
    doReload(1);
    check("R2 reload one count", count, 0);
    doTicks(4);
    check("R2 reload one status", status, 0);
    doReload(0);
    doTicks(2);
    check("R2 reload zero count", count, 0);
    check("R2 reload zero status", status, 0);
  endtask

  task automatic testPriority();
    doReload(2);
    check("R1 reload two", count, 2);
    doTicks(1);
    check("R8 down to one", count, 1);
    tick = 1'b1; reloadWrEn = 1'b1; reloadWrData = CNT_W'(7);
    step();
    tick = 1'b0; reloadWrEn = 1'b0;
    check("R10 reload beats tick", count, 7);
    check("R10 no expiry", status, 0);
    tick = 1'b1; ctrlWrEn = 1'b1; ctrlEnable = 1'b1; ctrlAutoReload = 1'b1;
    step();
    tick = 1'b0; ctrlWrEn = 1'b0;
    check("R10 ctrl beats tick", count, 7);
  endtask

  initial begin
    rstN = 1'b0; reloadWrEn = 0; reloadWrData = '0; ctrlWrEn = 0;
    ctrlEnable = 0; ctrlAutoReload = 0; tick = 0; statusClr = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDisabled();
    testAutoRun();
    testMask();
    testClear();
    testOneShot();
    testSmallReload();
    testPriority();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule